// File: doc/BRIEF.md
# Interleaved Burst Address Controller

This block sits at the front of a synchronous burst memory. On every rising clock edge it samples an external address and five controls. The controls are an active-low chip enable, two active-low address strobes, an active-low advance and a write request. The write request is the already-combined result of the write controls. From these the block decides whether a new access starts, whether a running burst steps on or pauses, or whether the device drops out of selection.

It drives a registered array address and an encoded cycle type. It also drives a flag that lets the array commit a write in the present cycle. The array itself, the byte-lane write logic and the output drivers use these outputs and are not part of this block.

Bursts step through an aligned group of four words in interleaved order. The low two bits of beat n are the loaded start bits XOR n. The two strobes have different priorities and chip enable masks them differently:
- The processor-side strobe always opens a read.
- The controller-side strobe opens a read or a write, as the write request asks.

Top module: `burst_addr_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are: `cycle_kind` = 2'b00 (unselected), `array_addr` = 0 and `write_ok` = 0.
- R2: With `ce_n`=0 and `ps_n`=0, the next cycle is a begin (`cycle_kind` = 2'b01). `array_addr` equals the sampled `addr_in`. `write_ok` is 0 whatever `wr_req` is.
- R3: With `ce_n`=1, `ps_n` is ignored. If `cs_n`=1, the block behaves exactly as it would with `ps_n`=1: no address is loaded, and a running burst continues or suspends as `adv_n` asks.
- R4: With `ce_n`=1 and `cs_n`=0, the next cycle is unselected (2'b00) and `write_ok`=0. While unselected, a cycle with both strobes high stays unselected and `array_addr` keeps its value.
- R5: With `ce_n`=0, `ps_n`=1 and `cs_n`=0, the next cycle is a begin (2'b01) at the sampled `addr_in`, and `write_ok` equals `wr_req`.
- R6: With `ce_n`=0 and both strobes low, the processor strobe wins. The cycle is a begin with `write_ok`=0.
- R7: In a selected state with both strobes high and `adv_n`=0, the cycle is a continue (2'b10). The low two address bits become start XOR n, where n counts steps since the load. Start 01 gives 01,00,11,10 and start 10 gives 10,11,00,01.
- R8: During a burst, bits [15:2] of `array_addr` stay at their loaded value. The fourth step wraps the address back to the start.
- R9: In a selected state with both strobes high and `adv_n`=1, the cycle is a suspend (2'b11) and `array_addr` is unchanged. In continue and suspend cycles, `write_ok` equals `wr_req`.
- R10: All outputs change only at the rising edge that samples the inputs producing them, and they hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 16 | External word address |
| ce_n | input | 1 | Chip enable, active low |
| ps_n | input | 1 | Processor-side address strobe, active low |
| cs_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_req | input | 1 | Combined write request from the write controls |
| array_addr | output | 16 | Registered array address |
| cycle_kind | output | 2 | 00 unselected, 01 begin, 10 continue, 11 suspend |
| write_ok | output | 1 | Write may be committed this cycle |

## Verification
Every result of this block is due one clock after the edge that samples its stimulus:
- the loaded or stepped address,
- the cycle code,
- the write permission.

The bench drives inputs on the falling edge and advances its behavioural model once per rising edge. It compares all three outputs one time unit after that rising edge, so each comparison sees exactly one register stage. Directed sequences cover both start patterns, the wrap, and strobe masking by chip enable. A randomised stretch then exercises the mixed orderings.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_BEGIN = 2'b01,
    CYC_CONT  = 2'b10,
    CYC_HOLD  = 2'b11
  } cyc_e;
endpackage

// File: rtl/burst_decode.sv
module burst_decode
  import burst_pkg::*;
(
  input  logic ce_n,
  input  logic ps_n,
  input  logic cs_n,
  input  logic adv_n,
  input  logic wr_req,
  input  logic selected,
  output cyc_e nxt_kind,
  output logic nxt_sel,
  output logic nxt_wr,
  output logic load,
  output logic step
);
  always_comb begin
    nxt_kind = CYC_IDLE;
    nxt_sel  = 1'b0;
    nxt_wr   = 1'b0;
    load     = 1'b0;
    step     = 1'b0;
    if (!ce_n && !ps_n) begin
      // processor strobe: always a read
      nxt_kind = CYC_BEGIN;
      nxt_sel  = 1'b1;
      load     = 1'b1;
    end else if (!cs_n) begin
      if (ce_n) begin
        nxt_kind = CYC_IDLE;
      end else begin
        nxt_kind = CYC_BEGIN;
        nxt_sel  = 1'b1;
        nxt_wr   = wr_req;
        load     = 1'b1;
      end
    end else if (selected) begin
      nxt_sel = 1'b1;
      nxt_wr  = wr_req;
      if (!adv_n) begin
        nxt_kind = CYC_CONT;
        step     = 1'b1;
      end else begin
        nxt_kind = CYC_HOLD;
      end
    end
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    base_hi_q;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nxt;
  logic [BURST_W-1:0] lo_nxt;

  assign cnt_nxt = cnt_q + 1'b1;

  // interleaved order: each low bit is start bit XOR count bit
  for (genvar i = 0; i < BURST_W; i++) begin : g_lo
    assign lo_nxt[i] = start_q[i] ^ cnt_nxt[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi_q <= '0;
      start_q   <= '0;
      cnt_q     <= '0;
      addr_q    <= '0;
    end else if (load) begin
      base_hi_q <= addr_in[ADDR_W-1:BURST_W];
      start_q   <= addr_in[BURST_W-1:0];
      cnt_q     <= '0;
      addr_q    <= addr_in;
    end else if (step) begin
      cnt_q  <= cnt_nxt;
      addr_q <= {base_hi_q, lo_nxt};
    end
  end

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W]));

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> addr_q == $past(addr_in));
endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ce_n,
  input  logic              ps_n,
  input  logic              cs_n,
  input  logic              adv_n,
  input  logic              wr_req,
  output logic [ADDR_W-1:0] array_addr,
  output logic [1:0]        cycle_kind,
  output logic              write_ok
);
  cyc_e kind_q, nxt_kind;
  logic sel_q, nxt_sel, nxt_wr, load, step;

  burst_decode u_dec (
    .ce_n     (ce_n),
    .ps_n     (ps_n),
    .cs_n     (cs_n),
    .adv_n    (adv_n),
    .wr_req   (wr_req),
    .selected (sel_q),
    .nxt_kind (nxt_kind),
    .nxt_sel  (nxt_sel),
    .nxt_wr   (nxt_wr),
    .load     (load),
    .step     (step)
  );

  burst_counter #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .addr_in (addr_in),
    .addr_q  (array_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= CYC_IDLE;
      sel_q    <= 1'b0;
      write_ok <= 1'b0;
    end else begin
      kind_q   <= nxt_kind;
      sel_q    <= nxt_sel;
      write_ok <= nxt_wr;
    end
  end

  assign cycle_kind = kind_q;

  // R2
  ps_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !ps_n) |=> (cycle_kind == CYC_BEGIN) && !write_ok);

  // R4
  deselect_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n && !cs_n) |=> (cycle_kind == CYC_IDLE) && !write_ok);

  // R3
  ps_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n && cs_n) |=> cycle_kind != CYC_BEGIN);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cycle_kind == CYC_HOLD) |-> $stable(array_addr));

  // R5
  cs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && ps_n && !cs_n) |=> write_ok == $past(wr_req));
endmodule

// File: tb/burst_addr_ctrl_bench.sv
module burst_addr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr_in;
  logic        ce_n, ps_n, cs_n, adv_n, wr_req;
  logic [15:0] array_addr;
  logic [1:0]  cycle_kind;
  logic        write_ok;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  bit          m_sel;
  int          m_kind;
  int          m_n;
  logic [15:0] m_base;
  bit          m_wr;
  logic [15:0] m_addr;

  always #2 clk = ~clk;

  burst_addr_ctrl u_burst_addr_ctrl (
    .clk(clk), .rst(rst), .addr_in(addr_in), .ce_n(ce_n), .ps_n(ps_n),
    .cs_n(cs_n), .adv_n(adv_n), .wr_req(wr_req), .array_addr(array_addr),
    .cycle_kind(cycle_kind), .write_ok(write_ok)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected < 5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic compare(string tag);
    vectors++;
    if (cycle_kind !== m_kind[1:0] || array_addr !== m_addr || write_ok !== m_wr) begin
      fails++;
      $display("FAIL %s: actual kind=%0d addr=%h wr=%0b, expected kind=%0d addr=%h wr=%0b",
               tag, cycle_kind, array_addr, write_ok, m_kind, m_addr, m_wr);
    end
  endtask

  // one clock: drive on falling edge, model the edge, compare just after it
  task automatic cyc(bit ce, bit p, bit c, bit adv, bit wr, logic [15:0] a, string tag);
    @(negedge clk);
    ce_n = ce; ps_n = p; cs_n = c; adv_n = adv; wr_req = wr; addr_in = a;
    if (!ce && !p) begin
      m_kind = 1; m_sel = 1; m_base = a; m_n = 0; m_wr = 0;
    end else if (!c) begin
      if (ce) begin
        m_kind = 0; m_sel = 0; m_wr = 0;
      end else begin
        m_kind = 1; m_sel = 1; m_base = a; m_n = 0; m_wr = wr;
      end
    end else if (!m_sel) begin
      m_kind = 0; m_wr = 0;
    end else if (!adv) begin
      m_kind = 2; m_n = (m_n + 1) % 4; m_wr = wr;
    end else begin
      m_kind = 3; m_wr = wr;
    end
    if (m_sel || m_kind == 1) m_addr = {m_base[15:2], m_base[1:0] ^ 2'(m_n)};
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    rst = 1'b1; ce_n = 1; ps_n = 1; cs_n = 1; adv_n = 1; wr_req = 0; addr_in = '0;
    m_sel = 0; m_kind = 0; m_n = 0; m_base = '0; m_wr = 0; m_addr = '0;
    repeat (2) @(posedge clk);
    #1;
    compare("R1");
    @(negedge clk);
    rst = 1'b0;

    // R2 processor strobe opens a read at start 01 even when write requested
    cyc(0, 0, 1, 1, 1, 16'hABC5, "R2");
    // R7 interleaved beats 00,11,10 then R8 wrap to 01
    cyc(1, 1, 1, 0, 0, 16'h0000, "R7");
    cyc(0, 1, 1, 0, 0, 16'h1234, "R7");
    cyc(0, 1, 1, 0, 0, 16'h1234, "R7");
    cyc(0, 1, 1, 0, 0, 16'h1234, "R8");
    // R9 suspend with write, address held
    cyc(0, 1, 1, 1, 1, 16'hFFFF, "R9");
    cyc(0, 1, 1, 1, 0, 16'hFFFF, "R9");
    // R5 controller strobe, write, start 10
    cyc(0, 1, 0, 1, 1, 16'h5A5A, "R5");
    cyc(0, 1, 1, 0, 1, 16'h0000, "R7");
    // R3 chip enable high masks processor strobe: continue, no load
    cyc(1, 0, 1, 0, 0, 16'h7777, "R3");
    cyc(1, 0, 1, 1, 1, 16'h7777, "R3");
    // R4 deselect, then stays unselected with address kept
    cyc(1, 1, 0, 0, 1, 16'h3333, "R4");
    cyc(0, 1, 1, 0, 1, 16'h4444, "R4");
    cyc(1, 0, 1, 1, 1, 16'h4444, "R4");
    // R6 both strobes low: read
    cyc(0, 0, 0, 1, 1, 16'h9002, "R6");
    // R9 processor begin followed by a write with advance high
    cyc(0, 1, 1, 1, 1, 16'h0000, "R9");
    // R5 controller strobe with read request
    cyc(0, 1, 0, 0, 0, 16'hC3C3, "R5");

    // R10 mixed random stimulus, compared every clock
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      cyc(r[0] & r[1], r[2] | r[3], r[4] | r[5], r[6], r[7], 16'($urandom), "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule